// File: doc/BRIEF.md
# Dual Bit-Serial CRC Generator and Checker for a Serial Peripheral Port

This block keeps two CRC accumulators next to a serial peripheral shifter. One accumulator follows the bits the shifter sends. The other follows the bits it receives. The shifter raises a one-cycle strobe for each bit on the clock edge where it samples data, which is selected by clock polarity and phase. This block does not see that edge choice. It only sees the strobe and the bit. Each strobe advances the matching accumulator by one bit, most significant bit first.

The generator polynomial is programmable. The frame format sets the CRC width: 8-bit frames use an 8-bit CRC, and 16-bit frames use a 16-bit CCITT-style CRC, normally with polynomial 0x1021. A rising edge on the enable input clears both accumulators. While enable is low, both accumulators hold their values.

In full-duplex operation the receiver appends the sender's CRC to the data. After the CRC frame has been received, a check strobe tests the receive accumulator against zero. A non-zero remainder raises a sticky error flag, which stays set until software clears it. In simplex operation no check is made, and software compares the two readable registers itself.

Top module: `spi_crc_pair`

## Requirements
- R1: The transmit and receive accumulators are independent. A transmit strobe changes only `tx_crc`, and a receive strobe changes only `rx_crc`.
- R2: On a strobe with enable high, the new value appears on the next clock.
  - The feedback bit is the input bit XOR the current top bit.
  - The register shifts left one place, filling with 0.
  - When the feedback bit is 1, `poly` is XORed into the result.
- R3: With `frame16`=1 the CRC is 16 bits wide and the top bit is bit 15. With poly 0x1021, the nine bytes 0x31..0x39 leave 0x31C3.
- R4: With `frame16`=0 the CRC is 8 bits wide and the top bit is bit 7. Only `poly[7:0]` is used, and bits 15:8 of the outputs read zero. With poly 0x07, the bytes 0x31..0x39 leave 0x00F4.
- R5: In a cycle where `crc_en` is high and was low in the previous cycle, both accumulators read zero on the next clock. This holds even if a strobe arrives in the same cycle.
- R6: While `crc_en` is low, bit strobes are ignored and both accumulators hold their values.
- R7: When `full_duplex`=1, `crc_en`=1 and `chk_stb`=1, `crc_err` is set on the next clock if `rx_crc` is non-zero. A zero `rx_crc` leaves `crc_err` unchanged.
- R8: `crc_err` stays set until `err_clr` is pulsed. `err_clr` clears it on the next clock, but a new mismatch in the same cycle wins and keeps it set.
- R9: When `full_duplex`=0, `chk_stb` never sets `crc_err`.
- R10: After synchronous reset, both accumulators and `crc_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crc_en | input | 1 | CRC enable level; its rising edge clears both accumulators |
| frame16 | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| poly | input | 16 | Generator polynomial without the implicit top term |
| full_duplex | input | 1 | 1 turns on the automatic receive check |
| tx_vld | input | 1 | Transmit bit strobe on the sampling edge |
| tx_bit | input | 1 | Transmitted bit |
| rx_vld | input | 1 | Receive bit strobe on the sampling edge |
| rx_bit | input | 1 | Received bit |
| chk_stb | input | 1 | Pulse after the last bit of the received CRC frame |
| err_clr | input | 1 | Clears the sticky error flag |
| tx_crc | output | 16 | Transmit accumulator |
| rx_crc | output | 16 | Receive accumulator |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
A corrupted accumulator bit shows on `tx_crc` or `rx_crc` in the cycle after the strobe that caused it, because both registers drive the ports directly. A wrong feedback tap or a wrong mask only shows up after several bits. The known-answer sums over nine bytes therefore exercise every tap in both widths. A fault in the check path shows on `crc_err` one cycle after `chk_stb`. Such a fault appears either as an error on a clean data-plus-CRC stream or as silence on a corrupted one.

// File: rtl/spi_crc_pkg.sv
// Package: shared widths for the dual serial CRC block.
// Assumes the widest supported CRC is 16 bits and the narrow one is 8 bits.
package spi_crc_pkg;
    localparam int CRC_MAX_W    = 16;
    localparam int CRC_NARROW_W = 8;
endpackage

// File: rtl/spi_crc_lane.sv
// Module: one bit-serial CRC accumulator.
// What it does: on each bit strobe, shifts the input bit into the accumulator
// using the programmed polynomial, in either the wide or the narrow width.
// Assumptions:
//   - clr has priority over a strobe.
//   - While en is low the value is frozen.
//   - In narrow mode the bits above NARROW_W are forced to zero.
module spi_crc_lane #(
    parameter int W        = spi_crc_pkg::CRC_MAX_W,
    parameter int NARROW_W = spi_crc_pkg::CRC_NARROW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         wide,
    input  logic [W-1:0] poly,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic [W-1:0] crc
);
    localparam int UPPER_W = W - NARROW_W;

    logic [W-1:0] crc_q;
    logic [W-1:0] step_val;
    logic [W-1:0] poly_eff;
    logic         top_bit;
    logic         fb;

    // Purpose: compute the one-bit update in the selected width.
    always_comb begin
        top_bit  = wide ? crc_q[W-1] : crc_q[NARROW_W-1];
        fb       = bit_in ^ top_bit;
        poly_eff = wide ? poly : {{UPPER_W{1'b0}}, poly[NARROW_W-1:0]};
        step_val = {crc_q[W-2:0], 1'b0} ^ (fb ? poly_eff : '0);
        if (!wide) begin
            step_val[W-1:NARROW_W] = '0;
        end
    end

    // Purpose: accumulator register with reset, clear, freeze and step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en && bit_vld) begin
            crc_q <= step_val;
        end
    end

    assign crc = crc_q;

    // R5: a clear always leaves zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0));
    // R6: frozen while disabled
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(crc_q));
    // R4: narrow step leaves upper bits zero
    a_r4_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && en && bit_vld && !clr) |=> (crc_q[W-1:NARROW_W] == '0));
    // R2: no strobe means no change
    a_r2_no_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(crc_q));
endmodule

// File: rtl/spi_crc_check.sv
// Module: automatic receive CRC check with a sticky error flag.
// What it does: after the CRC frame, a zero remainder means a good transfer;
// anything else sets the flag.
// Assumptions:
//   - chk_stb arrives at least one cycle after the last receive strobe.
//   - A new mismatch wins over err_clr in the same cycle.
module spi_crc_check #(
    parameter int W = spi_crc_pkg::CRC_MAX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         full_duplex,
    input  logic         chk_stb,
    input  logic         err_clr,
    input  logic [W-1:0] rx_crc,
    output logic         crc_err
);
    logic mismatch;
    logic err_q;

    // Purpose: decide whether this check strobe reports a mismatch.
    always_comb begin
        mismatch = full_duplex && en && chk_stb && (rx_crc != '0);
    end

    // Purpose: sticky error flag, set by a mismatch and cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (mismatch) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign crc_err = err_q;

    // R7: a non-zero remainder in full duplex raises the flag
    a_r7_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && en && chk_stb && rx_crc != '0) |=> crc_err);
    // R8: the flag is sticky without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !err_clr) |=> crc_err);
    // R9: simplex never raises the flag
    a_r9_simplex_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !crc_err) |=> !crc_err);
endmodule

// File: rtl/spi_crc_pair.sv
// Module: top level holding the transmit and receive CRC lanes and the
// receive check.
// What it does: detects the enable rising edge to clear both lanes, steers
// each bit strobe to its own lane, and reports the automatic check result.
// Assumptions:
//   - Bit strobes already mark the sampling edge chosen by clock polarity
//     and phase.
//   - Bits arrive most significant bit first.
module spi_crc_pair #(
    parameter int W        = spi_crc_pkg::CRC_MAX_W,
    parameter int NARROW_W = spi_crc_pkg::CRC_NARROW_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         crc_en,
    input  logic         frame16,
    input  logic [W-1:0] poly,
    input  logic         full_duplex,
    input  logic         tx_vld,
    input  logic         tx_bit,
    input  logic         rx_vld,
    input  logic         rx_bit,
    input  logic         chk_stb,
    input  logic         err_clr,
    output logic [W-1:0] tx_crc,
    output logic [W-1:0] rx_crc,
    output logic         crc_err
);
    localparam int LANES = 2;

    logic               en_q;
    logic               clr;
    logic [LANES-1:0]   lane_vld;
    logic [LANES-1:0]   lane_bit;
    logic [W-1:0]       lane_crc [LANES];

    // Purpose: remember last cycle's enable to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= crc_en;
        end
    end

    // Purpose: build the clear pulse and the per-lane strobe vectors.
    always_comb begin
        clr      = crc_en && !en_q;
        lane_vld = {rx_vld, tx_vld};
        lane_bit = {rx_bit, tx_bit};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        spi_crc_lane #(.W(W), .NARROW_W(NARROW_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .en      (crc_en),
            .wide    (frame16),
            .poly    (poly),
            .bit_vld (lane_vld[g]),
            .bit_in  (lane_bit[g]),
            .crc     (lane_crc[g])
        );
    end

    assign tx_crc = lane_crc[0];
    assign rx_crc = lane_crc[1];

    spi_crc_check #(.W(W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (crc_en),
        .full_duplex (full_duplex),
        .chk_stb     (chk_stb),
        .err_clr     (err_clr),
        .rx_crc      (rx_crc),
        .crc_err     (crc_err)
    );

    // R1: a transmit-only strobe leaves the receive lane unchanged
    a_r1_rx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_vld && !rx_vld && !clr) |=> $stable(rx_crc));
    // R1: a receive-only strobe leaves the transmit lane unchanged
    a_r1_tx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && !tx_vld && !clr) |=> $stable(tx_crc));
endmodule

// File: tb/spi_crc_pair_tb.sv
// Directed bench for spi_crc_pair: one task per scenario.
module spi_crc_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0;
    logic        frame16 = 1'b1;
    logic [15:0] poly = 16'h1021;
    logic        full_duplex = 1'b1;
    logic        tx_vld = 1'b0, tx_bit = 1'b0;
    logic        rx_vld = 1'b0, rx_bit = 1'b0;
    logic        chk_stb = 1'b0, err_clr = 1'b0;
    logic [15:0] tx_crc, rx_crc;
    logic        crc_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    spi_crc_pair u_dut (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frame16(frame16),
        .poly(poly), .full_duplex(full_duplex),
        .tx_vld(tx_vld), .tx_bit(tx_bit), .rx_vld(rx_vld), .rx_bit(rx_bit),
        .chk_stb(chk_stb), .err_clr(err_clr),
        .tx_crc(tx_crc), .rx_crc(rx_crc), .crc_err(crc_err)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference update written from the requirement text (R2, R3, R4).
    function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b,
                                             input logic [15:0] p, input logic w16);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = b[i] ^ (w16 ? r[15] : r[7]);
            r = r << 1;
            if (fb) r = r ^ (w16 ? p : {8'h00, p[7:0]});
            if (!w16) r[15:8] = 8'h00;
        end
        return r;
    endfunction

    // Strobe one byte into the selected lanes, then go idle.
    task automatic send_byte(input logic [7:0] b, input bit on_tx, input bit on_rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            tx_vld = on_tx; tx_bit = b[i];
            rx_vld = on_rx; rx_bit = b[i];
        end
        @(negedge clk);
        tx_vld = 1'b0; rx_vld = 1'b0;
    endtask

    task automatic enable_fresh();
        @(negedge clk); crc_en = 1'b0;
        @(negedge clk); crc_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 tx_crc", tx_crc, 16'h0000);
        check("R10 rx_crc", rx_crc, 16'h0000);
        check("R10 crc_err", {15'd0, crc_err}, 16'h0000);
    endtask

    task automatic t_known16();
        frame16 = 1'b1; poly = 16'h1021;
        enable_fresh();
        for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k), 1'b1, 1'b1);
        check("R3 tx 0x31C3", tx_crc, 16'h31C3);
        check("R3 rx 0x31C3", rx_crc, 16'h31C3);
    endtask

    task automatic t_isolation();
        logic [15:0] e;
        frame16 = 1'b1; poly = 16'h8005;
        enable_fresh();
        send_byte(8'hA5, 1'b1, 1'b0);
        send_byte(8'h3C, 1'b1, 1'b0);
        e = ref_byte(ref_byte(16'h0, 8'hA5, 16'h8005, 1'b1), 8'h3C, 16'h8005, 1'b1);
        check("R2 tx update", tx_crc, e);
        check("R1 rx untouched", rx_crc, 16'h0000);
        send_byte(8'h5A, 1'b0, 1'b1);
        check("R1 tx untouched", tx_crc, e);
        check("R2 rx update", rx_crc, ref_byte(16'h0, 8'h5A, 16'h8005, 1'b1));
    endtask

    task automatic t_known8();
        frame16 = 1'b0; poly = 16'hAB07;
        enable_fresh();
        for (int k = 0; k < 9; k++) send_byte(8'h31 + 8'(k), 1'b1, 1'b0);
        check("R4 tx 0xF4", tx_crc, 16'h00F4);
        frame16 = 1'b1; poly = 16'h1021;
    endtask

    task automatic t_freeze();
        logic [15:0] held;
        enable_fresh();
        send_byte(8'h77, 1'b1, 1'b1);
        held = tx_crc;
        @(negedge clk); crc_en = 1'b0;
        send_byte(8'hE1, 1'b1, 1'b1);
        check("R6 tx frozen", tx_crc, held);
        check("R6 rx frozen", rx_crc, held);
    endtask

    task automatic t_clear_edge();
        // crc_en is low here; raise it together with strobes
        @(negedge clk);
        crc_en = 1'b1; tx_vld = 1'b1; tx_bit = 1'b1; rx_vld = 1'b1; rx_bit = 1'b1;
        @(negedge clk);
        tx_vld = 1'b0; rx_vld = 1'b0;
        check("R5 tx cleared", tx_crc, 16'h0000);
        check("R5 rx cleared", rx_crc, 16'h0000);
    endtask

    task automatic t_duplex_check();
        logic [15:0] c;
        full_duplex = 1'b1; frame16 = 1'b1; poly = 16'h1021;
        enable_fresh();
        c = ref_byte(ref_byte(16'h0, 8'h12, poly, 1'b1), 8'h34, poly, 1'b1);
        send_byte(8'h12, 1'b0, 1'b1); send_byte(8'h34, 1'b0, 1'b1);
        send_byte(c[15:8], 1'b0, 1'b1); send_byte(c[7:0], 1'b0, 1'b1);
        check("R7 clean remainder", rx_crc, 16'h0000);
        @(negedge clk); chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0;
        check("R7 no error on clean", {15'd0, crc_err}, 16'h0000);
        enable_fresh();
        send_byte(8'h12, 1'b0, 1'b1); send_byte(8'h35, 1'b0, 1'b1);
        send_byte(c[15:8], 1'b0, 1'b1); send_byte(c[7:0], 1'b0, 1'b1);
        @(negedge clk); chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0;
        check("R7 error on corrupt", {15'd0, crc_err}, 16'h0001);
        repeat (5) @(negedge clk);
        check("R8 sticky", {15'd0, crc_err}, 16'h0001);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 cleared", {15'd0, crc_err}, 16'h0000);
        chk_stb = 1'b1; err_clr = 1'b1;
        @(negedge clk); chk_stb = 1'b0; err_clr = 1'b0;
        check("R8 set wins over clear", {15'd0, crc_err}, 16'h0001);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic t_simplex();
        full_duplex = 1'b0;
        enable_fresh();
        send_byte(8'hC3, 1'b0, 1'b1);
        check("R9 rx nonzero", {15'd0, rx_crc != 16'h0}, 16'h0001);
        @(negedge clk); chk_stb = 1'b1;
        @(negedge clk); chk_stb = 1'b0;
        check("R9 no check in simplex", {15'd0, crc_err}, 16'h0000);
        full_duplex = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known16();
        t_isolation();
        t_known8();
        t_freeze();
        t_clear_edge();
        t_duplex_check();
        t_simplex();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule